// File: doc/BRIEF.md
# Five-Way Locality Ownership Arbiter

This block decides which of five software localities owns a shared command interface. Each locality sees its own access register at offset zero of its own 4 KB window in a memory-mapped register space. Through that register a locality can ask for the interface, give it back, and find out whether it is the owner and whether any other locality is waiting. The command data path and interrupt delivery sit outside this block.

Accesses arrive on a single-cycle register port. The locality number is decoded from the address bits just above the 12-bit window offset. While nobody owns the interface and requests are waiting, the highest-numbered requester is granted on the next clock. Every change of owner, whether a grant or a release, raises a one-cycle event pulse. That pulse is meant to drive the locality-change interrupt source, which is status bit 2 of the interrupt logic. The current owner is also driven out directly.

Top module: `locality_arbiter`

## Requirements
- R1: Address bits [14:12] select locality 0 to 4, and the access register is the word at window offset 0x000. A read of any other offset, or of a window numbered 5 or higher, returns 0x00. Writes to those addresses have no effect.
- R2: Every read of an access register returns bit 7 set to 1.
- R3: Access register bit 5 reads 1 only in the window of the locality that currently owns the interface.
- R4: Writing 1 to bit 1 records a request for the writing locality. When nobody owns the interface, a pending request is granted on the following clock.
- R5: Bit 2 reads 1 when some locality other than the reader has a pending request. A locality's own pending request does not set its own bit 2.
- R6: When the owner writes 1 to bit 5, ownership is released. Any pending request is then granted one clock later.
- R7: When several requests are pending, the highest-numbered locality is granted.
- R8: A grant clears the request of the granted locality.
- R9: A bit-5 write from a locality that is not the owner clears only that locality's own pending request. Ownership is unchanged.
- R10: `loc_change` is high for exactly one cycle after each grant and after each release. It stays low otherwise.
- R11: Writes to bits 0, 2, 3, 4 and 6 have no effect, and those bits (and bit 6) read 0.
- R12: After reset nobody owns the interface, no request is pending, and `reg_rd_valid` and `loc_change` are 0.
- R13: A bit-1 write from the current owner is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address, locality in bits [14:12] |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, one cycle after the read strobe |
| reg_rd_valid | output | 1 | Marks the cycle in which `reg_rdata` holds read data |
| active_loc | output | 3 | Number of the owning locality |
| active_valid | output | 1 | 1 while some locality owns the interface |
| loc_change | output | 1 | One-cycle pulse on every grant and release |

## Verification
The bench builds the block with its default parameters: five localities, 4 KB windows and a 16-bit address. With these values, the fifth window and the unused locality codes 5 to 7 are both reachable from the address bus, so the decode boundary of R1 can be exercised directly. The 8-bit data word covers every flag position. Reads are queued as expected words and compared in order as they return. The owner outputs and the event pulse are checked on the clock after each grant and release.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int BIT_VALID  = 7;
  localparam int BIT_ACTIVE = 5;
  localparam int BIT_PEND   = 2;
  localparam int BIT_REQ    = 1;
endpackage

// File: rtl/loc_addr_decode.sv
module loc_addr_decode #(
  parameter int NUM_LOC   = 5,
  parameter int ADDR_W    = 16,
  parameter int WIN_SHIFT = 12,
  parameter int LOC_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [LOC_W-1:0]  loc
);
  localparam int TOP_LSB = WIN_SHIFT + LOC_W;
  localparam logic [LOC_W:0] LOC_LIMIT = (LOC_W+1)'(NUM_LOC);

  logic upper_zero;

  generate
    if (ADDR_W > TOP_LSB) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:TOP_LSB] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign loc = addr[WIN_SHIFT +: LOC_W];
  assign hit = upper_zero && (addr[WIN_SHIFT-1:0] == '0) && ({1'b0, loc} < LOC_LIMIT);
endmodule

// File: rtl/loc_req_tracker.sv
module loc_req_tracker #(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOC-1:0] set_vec,
  input  logic [NUM_LOC-1:0] clr_vec,
  input  logic [NUM_LOC-1:0] grant_vec,
  output logic [NUM_LOC-1:0] req_q
);
  generate
    for (genvar i = 0; i < NUM_LOC; i++) begin : g_req
      always_ff @(posedge clk) begin
        if (rst)                          req_q[i] <= 1'b0;
        else if (grant_vec[i] || clr_vec[i]) req_q[i] <= 1'b0;
        else if (set_vec[i])              req_q[i] <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/loc_grant_engine.sv
module loc_grant_engine #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOC-1:0] req_q,
  input  logic               release_i,
  output logic [NUM_LOC-1:0] grant_vec,
  output logic [LOC_W-1:0]   owner_idx,
  output logic               owner_valid,
  output logic               change_pulse
);
  logic [LOC_W-1:0] pick;
  logic             grant_any;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (req_q[i]) pick = LOC_W'(i);
    end
  end

  assign grant_any = !owner_valid && (req_q != '0);
  assign grant_vec = grant_any ? (NUM_LOC'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_valid  <= 1'b0;
      owner_idx    <= '0;
      change_pulse <= 1'b0;
    end else if (release_i) begin
      owner_valid  <= 1'b0;
      change_pulse <= 1'b1;
    end else if (grant_any) begin
      owner_valid  <= 1'b1;
      owner_idx    <= pick;
      change_pulse <= 1'b1;
    end else begin
      change_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter #(
  parameter int NUM_LOC   = 5,
  parameter int ADDR_W    = 16,
  parameter int WIN_SHIFT = 12,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rd_valid,
  output logic [$clog2(NUM_LOC)-1:0] active_loc,
  output logic              active_valid,
  output logic              loc_change
);
  import loc_arb_pkg::*;
  localparam int LOC_W = $clog2(NUM_LOC);

  logic               dec_hit;
  logic [LOC_W-1:0]   dec_loc;
  logic [NUM_LOC-1:0] req_q, set_vec, clr_vec, grant_vec, other_pend;
  logic               wr_hit, is_owner, release_w;
  logic [DATA_W-1:0]  rd_word;

  loc_addr_decode #(.NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .LOC_W(LOC_W))
    u_dec (.addr(reg_addr), .hit(dec_hit), .loc(dec_loc));

  assign wr_hit    = reg_wr_en && dec_hit;
  assign is_owner  = active_valid && (active_loc == dec_loc);
  assign release_w = wr_hit && is_owner && reg_wdata[BIT_ACTIVE];

  generate
    for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
      logic sel;
      assign sel           = wr_hit && !is_owner && (dec_loc == LOC_W'(i));
      assign set_vec[i]    = sel && reg_wdata[BIT_REQ] && !reg_wdata[BIT_ACTIVE];
      assign clr_vec[i]    = sel && reg_wdata[BIT_ACTIVE];
      assign other_pend[i] = |(req_q & ~(NUM_LOC'(1) << i));
    end
  endgenerate

  loc_req_tracker #(.NUM_LOC(NUM_LOC)) u_req (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .grant_vec(grant_vec), .req_q(req_q));

  loc_grant_engine #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_grant (
    .clk(clk), .rst(rst), .req_q(req_q), .release_i(release_w),
    .grant_vec(grant_vec), .owner_idx(active_loc), .owner_valid(active_valid),
    .change_pulse(loc_change));

  always_comb begin
    rd_word = '0;
    if (dec_hit) begin
      rd_word[BIT_VALID]  = 1'b1;
      rd_word[BIT_ACTIVE] = is_owner;
      rd_word[BIT_PEND]   = other_pend[dec_loc];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata    <= '0;
      reg_rd_valid <= 1'b0;
    end else begin
      reg_rd_valid <= reg_rd_en;
      reg_rdata    <= reg_rd_en ? rd_word : '0;
    end
  end

  assert_grant_highest_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(active_valid) |-> (($past(req_q) >> active_loc) == NUM_LOC'(1)));
  assert_grant_clears_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(active_valid) |-> !req_q[active_loc]);
  assert_pulse_grant_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(active_valid) |-> loc_change);
  assert_pulse_release_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(active_valid) |-> loc_change);
  assert_owner_held_R6: assert property (@(posedge clk) disable iff (rst)
    (active_valid && $past(active_valid)) |-> ($stable(active_loc) && !loc_change));
  assert_idle_grant_R4: assert property (@(posedge clk) disable iff (rst)
    (!active_valid && req_q != '0) |=> active_valid);
  assert_valid_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_valid && reg_rdata != '0) |-> reg_rdata[BIT_VALID]);
endmodule

// File: tb/locality_arbiter_test.sv
`timescale 1ns/1ps
module locality_arbiter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        reg_rd_valid;
  logic [2:0]  active_loc;
  logic        active_valid, loc_change;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  locality_arbiter uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rd_valid(reg_rd_valid), .active_loc(active_loc),
    .active_valid(active_valid), .loc_change(loc_change));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int loc, int off, logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 16'((loc << 12) | off); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(int loc, int off, logic [7:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = 16'((loc << 12) | off);
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic own(string tag, int v, int l, int p);
    chk({tag, " valid"}, int'(active_valid), v);
    if (v != 0) chk({tag, " loc"}, int'(active_loc), l);
    chk({tag, " pulse"}, int'(loc_change), p);
  endtask

  always @(negedge clk) begin
    if (!rst && reg_rd_valid) begin
      if (exp_q.size() == 0) chk("unexpected read", 1, 0);
      else chk(tag_q.pop_front(), int'(reg_rdata), int'(exp_q.pop_front()));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    own("R12 reset", 0, 0, 0);
    chk("R12 rd_valid", int'(reg_rd_valid), 0);
    rd(0, 0, 8'h80, "R2 R12 idle read");
    // R4 request and grant
    wr(2, 0, 8'h02);
    own("R4 before grant", 0, 0, 0);
    tick(); own("R4 R10 grant loc2", 1, 2, 1);
    tick(); own("R10 pulse one cycle", 1, 2, 0);
    rd(2, 0, 8'hA0, "R3 owner read");
    rd(0, 0, 8'h80, "R3 R8 non-owner read, own request cleared");
    // R5 pending others
    wr(1, 0, 8'h02);
    own("R5 no grant while owned", 1, 2, 0);
    rd(2, 0, 8'hA4, "R5 owner sees pending");
    rd(1, 0, 8'h80, "R5 own request not shown");
    wr(3, 0, 8'h02);
    wr(4, 0, 8'h02);
    // R6 release, R7 highest wins
    wr(2, 0, 8'h20);
    own("R6 R10 release", 0, 0, 1);
    tick(); own("R7 grant highest loc4", 1, 4, 1);
    rd(4, 0, 8'hA4, "R7 owner loc4");
    rd(3, 0, 8'h84, "R5 loc3 sees loc1 pending");
    // R9 non-owner relinquish
    wr(3, 0, 8'h20);
    own("R9 owner unchanged", 1, 4, 0);
    // R13 and R11 ignored writes
    wr(4, 0, 8'h02);
    own("R13 owner request ignored", 1, 4, 0);
    wr(4, 0, 8'h5D);
    own("R11 other bits ignored", 1, 4, 0);
    rd(4, 0, 8'hA4, "R11 bits read zero");
    wr(4, 0, 8'h20);
    own("R6 release loc4", 0, 0, 1);
    tick(); own("R9 loc3 request was cleared, loc1 wins", 1, 1, 1);
    rd(1, 0, 8'hA0, "R13 no request left from loc4");
    // R1 decode boundaries
    rd(1, 4, 8'h00, "R1 other offset reads zero");
    rd(5, 0, 8'h00, "R1 window 5 reads zero");
    rd(7, 0, 8'h00, "R1 window 7 reads zero");
    wr(5, 0, 8'h02);
    wr(0, 8, 8'h02);
    wr(1, 0, 8'h20);
    own("R6 release loc1", 0, 0, 1);
    tick(); own("R1 stray writes made no request", 0, 0, 0);
    rd(0, 0, 8'h80, "R1 loc0 idle");
    // re-grant of locality 0
    wr(0, 0, 8'h02);
    tick(); own("R4 grant loc0", 1, 0, 1);
    rd(0, 0, 8'hA0, "R3 loc0 owner");
    repeat (3) tick();
    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule